// File: doc/BRIEF.md
# Frame-Slip Transmit Elastic Store

This block absorbs the rate difference between a system-side byte stream and a line-side transmit stream that runs on its own clock. Whole frames are written on the system clock and read out on the transmit clock. Two frame formats are carried. The T1 format is 25 byte positions: position 0 holds the framing bit in its least significant bit, and the other 24 positions are channel slots. The E1 format is 32 byte slots. The store holds at most two complete frames that are waiting to be read.

The two clocks never agree exactly, so the store sometimes overflows or runs dry. It corrects this only at frame boundaries. On overflow, the frame that was just completed is discarded and the writer is never stalled. On underflow, the reader sends the frame it has just finished once more. In both cases frame alignment is kept on both sides. Each deletion raises a one-cycle full event in the write domain. Each repetition raises a one-cycle empty event in the read domain. Every slip of either kind also raises a one-cycle slip event in the read domain.

Frame-level pointers cross between the domains as Gray code through two-flop synchronizers. After reset, one all-zero frame is already committed, so the store starts half full.

Top module: `tx_elastic_store`

## Requirements
- R1: While either reset is low, and on the first cycle after it, every output is 0. The first frame read after reset is the all-zero frame present at reset, and no empty event comes with it.
- R2: With `mode_e1`=0, a read frame is 25 bytes long. With `mode_e1`=1, it is 32 bytes long. `rd_sof` marks byte 0 of each frame, so consecutive `rd_sof` pulses are exactly one frame length of valid read bytes apart.
- R3: A read request accepted on a rising `rd_clk` edge drives `rd_valid`, `rd_sof` and `rd_data` on that same edge. `rd_valid` is 0 after any edge without a request, and `rd_sof` and `ev_empty` are never 1 without `rd_valid`.
- R4: Every frame read out is an exact byte-for-byte copy of one written frame. Frames leave in the order they were written.
- R5: When the writer starts a new frame (`wr_en` and `wr_sof`) while two completed frames are still waiting, the frame just completed is discarded and never read. `ev_full` is 1 for exactly one `wr_clk` cycle right after that write, and a frame is skipped on the read side only if it was discarded this way.
- R6: When the reader reaches a frame boundary and no new complete frame is waiting, it sends the previous frame again. `ev_empty` is 1 in the same cycle as that frame's `rd_sof`. A frame that follows its predecessor normally never carries `ev_empty`.
- R7: `ev_slip` pulses once for each repetition, in the same cycle as `ev_empty`, and once for each deletion, a few `rd_clk` cycles after `ev_full`. Over a run, the number of slip pulses equals the number of full pulses plus the number of empty pulses.
- R8: Bytes written after reset and before the first `wr_sof` are ignored and never reach the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | System-side write clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | A write byte is present this cycle |
| wr_sof | input | 1 | The write byte is byte 0 of a frame |
| wr_data | input | 8 | Write byte |
| rd_clk | input | 1 | Line-side transmit clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Request for the next read byte |
| mode_e1 | input | 1 | 0 selects 25-byte T1 frames, 1 selects 32-byte E1 frames |
| rd_valid | output | 1 | Read byte is valid |
| rd_sof | output | 1 | Read byte is byte 0 of a frame |
| rd_data | output | 8 | Read byte |
| ev_full | output | 1 | One-cycle pulse (write domain): a frame was discarded |
| ev_empty | output | 1 | One-cycle pulse (read domain): a frame is being repeated |
| ev_slip | output | 1 | One-cycle pulse (read domain): a slip of either kind happened |

## Verification
The assertions assume that `mode_e1` does not change while the block is out of reset. They also assume that both resets are applied together, that frames are written back to back with `wr_sof` on each first byte, and that deletions are far enough apart for each one to reach the read domain before the next. The stimulus keeps to these conditions. It changes the mode only while reset is held and always writes complete frames. Its steady rate patterns (equal rates, the reader at half rate, the writer at two-thirds rate) make slips at least a frame apart. The bench's frame-level model identifies each read frame by its first byte and checks it against the set of frames it saw discarded.

// File: rtl/es_pkg.sv
`timescale 1ns/1ps
package es_pkg;

    localparam int BYTE_W      = 8;
    localparam int T1_FRAME_LEN = 25;
    localparam int E1_FRAME_LEN = 32;
    localparam int FRAME_SLOTS  = 4;

    typedef enum logic {
        WR_HUNT = 1'b0,
        WR_FILL = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_START = 1'b0,
        RD_BODY  = 1'b1
    } rd_state_t;

endpackage

// File: rtl/es_gray_sync.sv
`timescale 1ns/1ps
module es_gray_sync #(
    parameter int PW      = 3,
    parameter int RST_BIN = 0
) (
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    localparam logic [PW-1:0] RST_B = PW'(RST_BIN);
    localparam logic [PW-1:0] RST_G = RST_B ^ (RST_B >> 1);

    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= RST_G;
            sync_q <= RST_G;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_out[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end
endmodule

// File: rtl/es_frame_ram.sv
`timescale 1ns/1ps
module es_frame_ram #(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/es_wr_ctrl.sv
`timescale 1ns/1ps
module es_wr_ctrl
    import es_pkg::*;
#(
    parameter int PW      = 3,
    parameter int SW      = 2,
    parameter int OW      = 5,
    parameter int CW      = 6,
    parameter int CAP     = 2,
    parameter int T1_LEN  = 25,
    parameter int E1_LEN  = 32
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic             wr_sof,
    input  logic             mode_e1,
    input  logic [PW-1:0]    rptr_sync,
    output logic [PW-1:0]    wptr_bin,
    output logic [PW-1:0]    wptr_gray,
    output logic             mem_we,
    output logic [SW+OW-1:0] mem_waddr,
    output logic             ev_full,
    output logic             del_toggle
);
    wr_state_t     state_q, state_d;
    logic [CW-1:0] wcnt_q;
    logic [CW-1:0] flen;
    logic [PW-1:0] occ;
    logic [PW-1:0] wptr_d;
    logic          sof_hit;
    logic          room;
    logic          commit;
    logic          drop;

    assign flen    = mode_e1 ? CW'(E1_LEN) : CW'(T1_LEN);
    assign occ     = wptr_bin - rptr_sync;
    assign room    = occ < PW'(CAP);
    assign sof_hit = wr_en && wr_sof;

    always_comb begin
        commit = 1'b0;
        drop   = 1'b0;
        unique case (state_q)
            WR_HUNT: begin
                commit = 1'b0;
                drop   = 1'b0;
            end
            WR_FILL: begin
                commit = sof_hit && room;
                drop   = sof_hit && !room;
            end
        endcase
    end

    assign wptr_d = wptr_bin + (commit ? PW'(1) : PW'(0));

    always_comb begin
        mem_we    = wr_en && (wr_sof || (state_q == WR_FILL && wcnt_q < flen));
        mem_waddr = {wptr_d[SW-1:0], wr_sof ? OW'(0) : wcnt_q[OW-1:0]};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_HUNT: if (sof_hit) state_d = WR_FILL;
            WR_FILL: state_d = WR_FILL;
        endcase
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) state_q <= WR_HUNT;
        else           state_q <= state_d;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wcnt_q     <= '0;
            wptr_bin   <= PW'(1);
            wptr_gray  <= PW'(1);
            ev_full    <= 1'b0;
            del_toggle <= 1'b0;
        end else begin
            if (sof_hit) begin
                wcnt_q <= CW'(1);
            end else if (wr_en && state_q == WR_FILL && wcnt_q < flen) begin
                wcnt_q <= wcnt_q + CW'(1);
            end
            wptr_bin   <= wptr_d;
            wptr_gray  <= wptr_d ^ (wptr_d >> 1);
            ev_full    <= drop;
            del_toggle <= del_toggle ^ drop;
        end
    end
endmodule

// File: rtl/es_rd_ctrl.sv
`timescale 1ns/1ps
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PW      = 3,
    parameter int SW      = 2,
    parameter int OW      = 5,
    parameter int CW      = 6,
    parameter int T1_LEN  = 25,
    parameter int E1_LEN  = 32
) (
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    input  logic             mode_e1,
    input  logic [PW-1:0]    wptr_sync,
    input  logic             del_toggle,
    input  logic [DW-1:0]    mem_rdata,
    output logic [SW+OW-1:0] mem_raddr,
    output logic [PW-1:0]    rptr_gray,
    output logic             rd_valid,
    output logic             rd_sof,
    output logic [DW-1:0]    rd_data,
    output logic             ev_empty,
    output logic             ev_slip
);
    rd_state_t     state_q, state_d;
    logic [CW-1:0] rcnt_q;
    logic [CW-1:0] flen;
    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rptr_d;
    logic [SW-1:0] rslot_q;
    logic [SW-1:0] slot_sel;
    logic          avail;
    logic          fetch;
    logic          take;
    logic          repeat_now;
    logic [2:0]    tog_q;
    logic          del_edge;
    logic          del_pend_q;

    assign flen       = mode_e1 ? CW'(E1_LEN) : CW'(T1_LEN);
    assign avail      = wptr_sync != rptr_q;
    assign fetch      = rd_en && (state_q == RD_START);
    assign take       = fetch && avail;
    assign repeat_now = fetch && !avail;
    assign slot_sel   = avail ? rptr_q[SW-1:0] : rslot_q;
    assign rptr_d     = rptr_q + (take ? PW'(1) : PW'(0));
    assign del_edge   = tog_q[1] ^ tog_q[2];

    always_comb begin
        mem_raddr = {rslot_q, rcnt_q[OW-1:0]};
        unique case (state_q)
            RD_START: mem_raddr = {slot_sel, OW'(0)};
            RD_BODY:  mem_raddr = {rslot_q, rcnt_q[OW-1:0]};
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_START: if (rd_en) state_d = RD_BODY;
            RD_BODY:  if (rd_en && rcnt_q == flen - CW'(1)) state_d = RD_START;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) state_q <= RD_START;
        else           state_q <= state_d;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rcnt_q     <= '0;
            rptr_q     <= '0;
            rptr_gray  <= '0;
            rslot_q    <= '0;
            rd_valid   <= 1'b0;
            rd_sof     <= 1'b0;
            rd_data    <= '0;
            ev_empty   <= 1'b0;
            ev_slip    <= 1'b0;
            tog_q      <= '0;
            del_pend_q <= 1'b0;
        end else begin
            if (fetch) begin
                rcnt_q  <= CW'(1);
                rslot_q <= slot_sel;
            end else if (rd_en) begin
                rcnt_q <= rcnt_q + CW'(1);
            end
            rptr_q    <= rptr_d;
            rptr_gray <= rptr_d ^ (rptr_d >> 1);
            rd_valid  <= rd_en;
            rd_sof    <= fetch;
            if (rd_en) rd_data <= mem_rdata;
            ev_empty  <= repeat_now;
            tog_q     <= {tog_q[1:0], del_toggle};
            if (repeat_now) begin
                ev_slip    <= 1'b1;
                del_pend_q <= del_pend_q | del_edge;
            end else if (del_pend_q || del_edge) begin
                ev_slip    <= 1'b1;
                del_pend_q <= 1'b0;
            end else begin
                ev_slip <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_elastic_store.sv
`timescale 1ns/1ps
module tx_elastic_store
    import es_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter int T1_LEN  = T1_FRAME_LEN,
    parameter int E1_LEN  = E1_FRAME_LEN,
    parameter int NSLOT   = FRAME_SLOTS
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              mode_e1,
    output logic              rd_valid,
    output logic              rd_sof,
    output logic [DATA_W-1:0] rd_data,
    output logic              ev_full,
    output logic              ev_empty,
    output logic              ev_slip
);
    localparam int SW  = $clog2(NSLOT);
    localparam int PW  = SW + 1;
    localparam int OW  = $clog2(E1_LEN);
    localparam int CW  = OW + 1;
    localparam int AW  = SW + OW;
    localparam int CAP = NSLOT - 2;

    logic [PW-1:0] wr_bin;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] rd_sync_bin;
    logic [PW-1:0] wr_sync_bin;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic          del_toggle;

    es_wr_ctrl #(
        .PW(PW), .SW(SW), .OW(OW), .CW(CW), .CAP(CAP),
        .T1_LEN(T1_LEN), .E1_LEN(E1_LEN)
    ) u_wr (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .wr_en      (wr_en),
        .wr_sof     (wr_sof),
        .mode_e1    (mode_e1),
        .rptr_sync  (rd_sync_bin),
        .wptr_bin   (wr_bin),
        .wptr_gray  (wr_gray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .ev_full    (ev_full),
        .del_toggle (del_toggle)
    );

    es_gray_sync #(.PW(PW), .RST_BIN(0)) u_rptr_sync (
        .dst_clk   (wr_clk),
        .dst_rst_n (wr_rst_n),
        .gray_in   (rd_gray),
        .bin_out   (rd_sync_bin)
    );

    es_gray_sync #(.PW(PW), .RST_BIN(1)) u_wptr_sync (
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .gray_in   (wr_gray),
        .bin_out   (wr_sync_bin)
    );

    es_frame_ram #(.DW(DATA_W), .AW(AW)) u_ram (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    (wr_data),
        .raddr    (mem_raddr),
        .rdata    (mem_rdata)
    );

    es_rd_ctrl #(
        .DW(DATA_W), .PW(PW), .SW(SW), .OW(OW), .CW(CW),
        .T1_LEN(T1_LEN), .E1_LEN(E1_LEN)
    ) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_en      (rd_en),
        .mode_e1    (mode_e1),
        .wptr_sync  (wr_sync_bin),
        .del_toggle (del_toggle),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rptr_gray  (rd_gray),
        .rd_valid   (rd_valid),
        .rd_sof     (rd_sof),
        .rd_data    (rd_data),
        .ev_empty   (ev_empty),
        .ev_slip    (ev_slip)
    );
endmodule

// File: rtl/tx_elastic_store_checker.sv
`timescale 1ns/1ps
module tx_elastic_store_checker #(
    parameter int PW  = 3,
    parameter int CAP = 2
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          wr_en,
    input logic          wr_sof,
    input logic          ev_full,
    input logic          rd_en,
    input logic          rd_valid,
    input logic          rd_sof,
    input logic          ev_empty,
    input logic          ev_slip,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_sync_bin
);
    // R3: a request is answered on the same edge
    a_r3_valid_follows_request: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n) rd_en |=> rd_valid);
    a_r3_idle_without_request: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n) !rd_en |=> !rd_valid);
    a_r3_sof_needs_valid: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n) rd_sof |-> rd_valid);

    // R6: a repetition is flagged on the first byte of the repeated frame
    a_r6_empty_on_frame_start: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n) ev_empty |-> rd_sof);

    // R7: every repetition is also a slip
    a_r7_empty_is_slip: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n) ev_empty |-> ev_slip);

    // R5: deletion pulse is one cycle wide and follows a frame start
    a_r5_full_single_cycle: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n) ev_full |=> !ev_full);
    a_r5_full_after_frame_start: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n) ev_full |-> $past(wr_en && wr_sof));
    a_r5_capacity_bound: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n) (wr_bin - rd_sync_bin) <= PW'(CAP));
    a_r5_pointer_gray_step: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n) $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

bind tx_elastic_store tx_elastic_store_checker #(.PW(PW), .CAP(CAP)) i_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_en       (wr_en),
    .wr_sof      (wr_sof),
    .ev_full     (ev_full),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_sof      (rd_sof),
    .ev_empty    (ev_empty),
    .ev_slip     (ev_slip),
    .wr_bin      (wr_bin),
    .wr_gray     (wr_gray),
    .rd_sync_bin (rd_sync_bin)
);

// File: tb/test_tx_elastic_store.sv
`timescale 1ns/1ps
module test_tx_elastic_store;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       wr_en, wr_sof, rd_en, mode_e1;
    logic [7:0] wr_data;
    logic       rd_valid, rd_sof, ev_full, ev_empty, ev_slip;
    logic [7:0] rd_data;

    tx_elastic_store i_tx_elastic_store (
        .wr_clk   (clk),
        .wr_rst_n (rst_n),
        .wr_en    (wr_en),
        .wr_sof   (wr_sof),
        .wr_data  (wr_data),
        .rd_clk   (clk),
        .rd_rst_n (rst_n),
        .rd_en    (rd_en),
        .mode_e1  (mode_e1),
        .rd_valid (rd_valid),
        .rd_sof   (rd_sof),
        .rd_data  (rd_data),
        .ev_full  (ev_full),
        .ev_empty (ev_empty),
        .ev_slip  (ev_slip)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state
    int flen, wid, wk, pending_done, prev_id, cur_id, rk;
    int full_cnt, empty_cnt, slip_cnt;
    bit last_ren;
    bit deleted [256];

    function automatic logic [7:0] fdata(input int n, input int k);
        if (n == 0) return 8'd0;
        if (k == 0) return 8'(n);
        return 8'((n * 5 + k * 29 + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic observe();
        chk(rd_valid == last_ren, "R3 rd_valid follows request", int'(rd_valid), int'(last_ren));
        if (ev_full) begin
            full_cnt++;
            if (pending_done > 0) deleted[pending_done] = 1'b1;
        end
        if (ev_slip) slip_cnt++;
        if (ev_empty) begin
            empty_cnt++;
            chk(ev_slip, "R7 slip with repetition", int'(ev_slip), 1);
        end
        if (rd_valid) begin
            if (rd_sof) begin
                int n;
                n = int'(rd_data);
                if (prev_id < 0) begin
                    chk(n == 0, "R1 first frame is reset frame", n, 0);
                    chk(!ev_empty, "R1 no repeat on first frame", int'(ev_empty), 0);
                end else begin
                    chk(rk == flen, "R2 frame length", rk, flen);
                    if (n == prev_id) begin
                        chk(ev_empty, "R6 repeat flagged", int'(ev_empty), 1);
                    end else begin
                        chk(!ev_empty, "R6 no spurious empty", int'(ev_empty), 0);
                        chk(n > prev_id, "R4 frame order", n, prev_id + 1);
                        for (int j = prev_id + 1; j < n; j++) begin
                            chk(deleted[j], "R5 skipped frame was discarded", j, -1);
                        end
                        chk(!deleted[n], "R5 discarded frame read", n, -1);
                    end
                end
                prev_id = n;
                cur_id  = n;
                rk      = 0;
            end else if (prev_id < 0) begin
                chk(1'b0, "R2 first byte lacks rd_sof", int'(rd_sof), 1);
            end
            chk(rd_data == fdata(cur_id, rk), "R4 frame byte", int'(rd_data), int'(fdata(cur_id, rk)));
            rk++;
        end else begin
            chk(!rd_sof && !ev_empty, "R3 markers without valid", int'(rd_sof), 0);
        end
    endtask

    task automatic step(input bit wen, input bit ren);
        @(negedge clk);
        observe();
        wr_en = wen;
        wr_sof = 1'b0;
        wr_data = 8'd0;
        if (wen) begin
            wr_sof  = (wk == 0);
            wr_data = fdata(wid, wk);
            if (wk == 0 && wid > 1) pending_done = wid - 1;
            wk++;
            if (wk == flen) begin
                wk = 0;
                wid++;
            end
        end
        rd_en = ren;
        last_ren = ren;
    endtask

    task automatic run_mode(input bit e1);
        int f0, e0;
        rst_n = 1'b0;
        mode_e1 = e1;
        flen = e1 ? 32 : 25;
        wr_en = 0; wr_sof = 0; wr_data = 0; rd_en = 0;
        wid = 1; wk = 0; pending_done = 0; prev_id = -1; cur_id = 0; rk = 0;
        full_cnt = 0; empty_cnt = 0; slip_cnt = 0; last_ren = 0;
        for (int i = 0; i < 256; i++) deleted[i] = 1'b0;
        repeat (4) @(negedge clk);
        chk({rd_valid, rd_sof, rd_data, ev_full, ev_empty, ev_slip} == '0, "R1 outputs low in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rd_valid, rd_sof, rd_data, ev_full, ev_empty, ev_slip} == '0, "R1 outputs low after reset", int'(rd_valid), 0);
        // R8: stray bytes before the first frame start
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            observe();
            wr_en = 1'b1; wr_sof = 1'b0; wr_data = 8'hA5; rd_en = 1'b0; last_ren = 1'b0;
        end
        for (int c = 0; c < 1800; c++) step(1'b1, 1'b1);
        f0 = full_cnt;
        for (int c = 0; c < 1800; c++) step(1'b1, (c % 2) == 0);
        chk(full_cnt > f0, "R5 overflow discards frames", full_cnt - f0, 1);
        e0 = empty_cnt;
        for (int c = 0; c < 1800; c++) step((c % 3) != 0, 1'b1);
        chk(empty_cnt > e0, "R6 underflow repeats frames", empty_cnt - e0, 1);
        for (int c = 0; c < 12; c++) step(1'b0, 1'b0);
        chk(slip_cnt == full_cnt + empty_cnt, "R7 slip count", slip_cnt, full_cnt + empty_cnt);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule